// File: doc/BRIEF.md
# Type-Aware ALU with Zero Flag

This block is the execution stage of a small 32-bit RISC core. It takes a full instruction word and the three operand values read from the register file (first source, second source and the destination register's current contents). From the 2-bit type field and the 5-bit function field it selects an arithmetic, logic or shift operation and picks the second operand: the second source register, the destination register value (for the equality branch), a 14-bit immediate extended with zeros or with sign, or a 5-bit constant shift amount.

The result is combinational. It goes to the register file write port, or it serves as the data memory address for loads and stores. A registered zero flag records the outcome of the last valid operation. For the compare operation it holds a signed less-than test instead of a zero test. A combinational branch-equal output serves the branch instruction. Type/function pairs with no defined operation raise an illegal-operation output. Jump-type words pass through without any ALU effect.

Instruction fields: function [31:27], first source [26:22], destination [21:17], second source [16:12], constant shift amount [11:7], 14-bit immediate [16:3], type [2:1], stop bit [0]. Types are 00 register, 01 jump, 10 immediate, 11 shift.

Top module: `type_alu`

## Requirements
- R1: For register type (00), function 0 gives rs1 AND rs2, function 1 gives rs1 + rs2, and function 2 gives rs1 - rs2, all modulo 2^32.
- R2: Register-type function 3 (compare) drives result = rs1 - rs2. After a valid cycle the zero flag holds the signed test rs1 < rs2.
- R3: For immediate type (10), function 0 gives rs1 AND the zero-extended immediate [16:3], and function 1 gives rs1 + the sign-extended immediate.
- R4: Immediate-type functions 2 (load) and 3 (store) give the address rs1 + the sign-extended immediate.
- R5: Immediate-type function 4 (branch) drives branch_eq = (rs1 == rd) in the same cycle and result = rs1 - rd. branch_eq is low for every other operation.
- R6: For shift type (11), function 0 shifts rs1 left and function 1 shifts it logically right (zero fill), by the constant field [11:7].
- R7: Shift-type function 2 shifts left and function 3 shifts logically right, by the low 5 bits of rs2. The upper bits of rs2 are ignored.
- R8: On each clock edge with op_valid high and a legal non-compare, non-jump operation, the zero flag becomes (result == 0).
- R9: While op_valid is low, the zero flag keeps its value.
- R10: Undefined pairs (register function above 3, immediate function above 4, shift function above 3) give result 0 and illegal_op high, and leave the zero flag unchanged.
- R11: Jump type (01) gives result 0 and illegal_op low, and leaves the zero flag unchanged.
- R12: Synchronous active-high reset clears the zero flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction on instr is executed this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | First source register value |
| rs2_val | input | XLEN | Second source register value |
| rd_val | input | XLEN | Destination register current value |
| result | output | XLEN | Operation result / memory address |
| zero_flag | output | 1 | Registered flag of the last valid operation |
| branch_eq | output | 1 | rs1 equals rd on a branch instruction |
| illegal_op | output | 1 | Undefined type/function combination |

## Verification
The only state is the zero flag. A wrong flag update shows at the flag output one clock after the offending valid cycle. An update on an idle, illegal or jump cycle, or a compare flag computed unsigned or as a zero test, therefore shows within one cycle. The bench reads the flag at the next falling edge after each operation and after idle cycles. It checks every operand decode and immediate extension through the combinational result in the same cycle, with values chosen so that sign versus zero extension, arithmetic versus logical right shift, and masking of the variable shift amount each give a different result.

// File: rtl/type_alu_pkg.sv
package type_alu_pkg;

  localparam int INSTR_W = 32;
  localparam int FUNC_LO = 27;
  localparam int IMM_W   = 14;
  localparam int IMM_LO  = 3;
  localparam int SA_W    = 5;
  localparam int SA_LO   = 7;
  localparam int TYPE_LO = 1;

  typedef enum logic [1:0] {
    TY_REG = 2'b00,
    TY_JMP = 2'b01,
    TY_IMM = 2'b10,
    TY_SHF = 2'b11
  } itype_e;

  typedef enum logic [2:0] {
    OP_AND,
    OP_ADD,
    OP_SUB,
    OP_SHL,
    OP_SHR,
    OP_NONE
  } aluop_e;

  typedef enum logic [1:0] {
    FL_HOLD,
    FL_ZERO,
    FL_LESS
  } flmode_e;

  typedef struct packed {
    aluop_e  op;
    flmode_e fl;
    logic    illegal;
    logic    beq;
  } ctrl_t;

endpackage

// File: rtl/type_alu_decode.sv
module type_alu_decode
  import type_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [XLEN-1:0]    rs2_val,
  input  logic [XLEN-1:0]    rd_val,
  output ctrl_t              ctrl,
  output logic [XLEN-1:0]    opb
);

  localparam int IMM_PAD = XLEN - IMM_W;
  localparam int SA_PAD  = XLEN - SA_W;

  logic [4:0]       func;
  itype_e           ity;
  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  imm_z;
  logic [XLEN-1:0]  imm_s;
  logic [XLEN-1:0]  sa_z;

  assign func  = instr[FUNC_LO +: 5];
  assign ity   = itype_e'(instr[TYPE_LO +: 2]);
  assign imm   = instr[IMM_LO +: IMM_W];
  assign imm_z = {{IMM_PAD{1'b0}}, imm};
  assign imm_s = {{IMM_PAD{imm[IMM_W-1]}}, imm};
  assign sa_z  = {{SA_PAD{1'b0}}, instr[SA_LO +: SA_W]};

  always_comb begin
    ctrl = '{op: OP_NONE, fl: FL_HOLD, illegal: 1'b0, beq: 1'b0};
    opb  = rs2_val;
    unique case (ity)
      TY_REG: begin
        ctrl.fl = FL_ZERO;
        case (func)
          5'd0: ctrl.op = OP_AND;
          5'd1: ctrl.op = OP_ADD;
          5'd2: ctrl.op = OP_SUB;
          5'd3: begin
            ctrl.op = OP_SUB;
            ctrl.fl = FL_LESS;
          end
          default: begin
            ctrl.fl      = FL_HOLD;
            ctrl.illegal = 1'b1;
          end
        endcase
      end
      TY_IMM: begin
        ctrl.fl = FL_ZERO;
        opb     = imm_s;
        case (func)
          5'd0: begin
            ctrl.op = OP_AND;
            opb     = imm_z;
          end
          5'd1, 5'd2, 5'd3: ctrl.op = OP_ADD;
          5'd4: begin
            ctrl.op  = OP_SUB;
            ctrl.beq = 1'b1;
            opb      = rd_val;
          end
          default: begin
            ctrl.fl      = FL_HOLD;
            ctrl.illegal = 1'b1;
          end
        endcase
      end
      TY_SHF: begin
        ctrl.fl = FL_ZERO;
        case (func)
          5'd0: begin
            ctrl.op = OP_SHL;
            opb     = sa_z;
          end
          5'd1: begin
            ctrl.op = OP_SHR;
            opb     = sa_z;
          end
          5'd2: ctrl.op = OP_SHL;
          5'd3: ctrl.op = OP_SHR;
          default: begin
            ctrl.fl      = FL_HOLD;
            ctrl.illegal = 1'b1;
          end
        endcase
      end
      default: begin
        ctrl.op = OP_NONE;
      end
    endcase
  end

endmodule

// File: rtl/type_alu_shift.sv
module type_alu_shift #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] val,
  input  logic [SHW-1:0]  amt,
  input  logic            left,
  output logic [XLEN-1:0] out
);

  logic [XLEN-1:0] rin;
  logic [XLEN-1:0] stg [SHW+1];

  for (genvar i = 0; i < XLEN; i++) begin : g_rev_in
    assign rin[i] = left ? val[XLEN-1-i] : val[i];
  end

  assign stg[0] = rin;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    assign stg[s+1] = amt[s] ? (stg[s] >> (1 << s)) : stg[s];
  end

  for (genvar i = 0; i < XLEN; i++) begin : g_rev_out
    assign out[i] = left ? stg[SHW][XLEN-1-i] : stg[SHW][i];
  end

endmodule

// File: rtl/type_alu_exec.sv
module type_alu_exec
  import type_alu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  aluop_e          op,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] res,
  output logic            less
);

  logic [XLEN-1:0] sh_out;
  logic            sh_left;

  assign sh_left = (op == OP_SHL);

  type_alu_shift #(.XLEN(XLEN)) u_shift (
    .val  (opa),
    .amt  (opb[SHW-1:0]),
    .left (sh_left),
    .out  (sh_out)
  );

  assign less = $signed(opa) < $signed(opb);

  always_comb begin
    case (op)
      OP_AND:  res = opa & opb;
      OP_ADD:  res = opa + opb;
      OP_SUB:  res = opa - opb;
      OP_SHL,
      OP_SHR:  res = sh_out;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/type_alu_zflag.sv
module type_alu_zflag
  import type_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  flmode_e         mode,
  input  logic [XLEN-1:0] res,
  input  logic            less,
  output logic            flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (en) begin
      case (mode)
        FL_ZERO: flag <= (res == '0);
        FL_LESS: flag <= less;
        default: flag <= flag;
      endcase
    end
  end

endmodule

// File: rtl/type_alu.sv
module type_alu
  import type_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic [XLEN-1:0] rd_val,
  output logic [XLEN-1:0] result,
  output logic            zero_flag,
  output logic            branch_eq,
  output logic            illegal_op
);

  ctrl_t           ctrl;
  logic [XLEN-1:0] opb;
  logic            less;

  type_alu_decode #(.XLEN(XLEN)) u_dec (
    .instr   (instr),
    .rs2_val (rs2_val),
    .rd_val  (rd_val),
    .ctrl    (ctrl),
    .opb     (opb)
  );

  type_alu_exec #(.XLEN(XLEN)) u_exec (
    .op   (ctrl.op),
    .opa  (rs1_val),
    .opb  (opb),
    .res  (result),
    .less (less)
  );

  type_alu_zflag #(.XLEN(XLEN)) u_flag (
    .clk  (clk),
    .rst  (rst),
    .en   (op_valid),
    .mode (ctrl.fl),
    .res  (result),
    .less (less),
    .flag (zero_flag)
  );

  assign branch_eq  = ctrl.beq && (rs1_val == rd_val);
  assign illegal_op = ctrl.illegal;

endmodule

// File: rtl/type_alu_checker.sv
module type_alu_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            op_valid,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] result,
  input logic            zero_flag,
  input logic            branch_eq,
  input logic            illegal_op
);

  logic is_cmp;
  logic is_jmp;
  assign is_cmp = (instr[2:1] == 2'b00) && (instr[31:27] == 5'd3);
  assign is_jmp = (instr[2:1] == 2'b01);

  p_reset_clear_r12: assert property (@(posedge clk)
    rst |=> !zero_flag);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(zero_flag));

  p_illegal_out_r10: assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> (result == '0) && !branch_eq);

  p_illegal_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && illegal_op) |=> $stable(zero_flag));

  p_jump_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_jmp) |=> $stable(zero_flag));

  p_jump_legal_r11: assert property (@(posedge clk) disable iff (rst)
    is_jmp |-> !illegal_op && (result == '0));

  p_flag_track_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !illegal_op && !is_jmp && !is_cmp)
      |=> zero_flag == ($past(result) == '0));

  p_beq_only_r5: assert property (@(posedge clk) disable iff (rst)
    branch_eq |-> (instr[2:1] == 2'b10) && (instr[31:27] == 5'd4));

endmodule

bind type_alu type_alu_checker #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_valid   (op_valid),
  .instr      (instr),
  .result     (result),
  .zero_flag  (zero_flag),
  .branch_eq  (branch_eq),
  .illegal_op (illegal_op)
);

// File: tb/type_alu_bench.sv
`timescale 1ns/1ps
module type_alu_bench;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            op_valid = 1'b0;
  logic [31:0]     instr = '0;
  logic [XLEN-1:0] rs1_val = '0;
  logic [XLEN-1:0] rs2_val = '0;
  logic [XLEN-1:0] rd_val = '0;
  logic [XLEN-1:0] result;
  logic            zero_flag;
  logic            branch_eq;
  logic            illegal_op;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  type_alu #(.XLEN(XLEN)) u_type_alu (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .instr      (instr),
    .rs1_val    (rs1_val),
    .rs2_val    (rs2_val),
    .rd_val     (rd_val),
    .result     (result),
    .zero_flag  (zero_flag),
    .branch_eq  (branch_eq),
    .illegal_op (illegal_op)
  );

  function automatic logic [31:0] mk(input logic [4:0] fn, input logic [1:0] ty,
                                     input logic [13:0] pay);
    return {fn, 5'd1, 5'd2, pay, ty, 1'b0};
  endfunction

  function automatic logic [13:0] shp(input logic [4:0] sa);
    return {5'd3, sa, 4'b0000};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, check combinational outputs, then the flag one edge later
  task automatic run_op(input string tag, input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] d, input logic vld,
                        input logic [31:0] eres, input logic eflag, input logic ebeq,
                        input logic eill);
    @(negedge clk);
    instr = ins; rs1_val = a; rs2_val = b; rd_val = d; op_valid = vld;
    #1;
    chk({tag, " result"}, result, eres);
    chk({tag, " branch_eq"}, {31'b0, branch_eq}, {31'b0, ebeq});
    chk({tag, " illegal"}, {31'b0, illegal_op}, {31'b0, eill});
    @(negedge clk);
    op_valid = 1'b0;
    chk({tag, " zero_flag"}, {31'b0, zero_flag}, {31'b0, eflag});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12 reset flag", {31'b0, zero_flag}, 32'd0);
    run_op("R8 set flag", mk(5'd2, 2'b00, 14'd0), 32'd9, 32'd9, 32'd0, 1'b1, 32'd0, 1'b1, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R12 mid reset flag", {31'b0, zero_flag}, 32'd0);
  endtask

  task automatic t_reg();
    run_op("R1 AND", mk(5'd0, 2'b00, 14'd0), 32'hF0F0_00FF, 32'h0FF0_F00F, 32'd0, 1'b1,
           32'h00F0_000F, 1'b0, 1'b0, 1'b0);
    run_op("R1 ADD wrap", mk(5'd1, 2'b00, 14'd0), 32'h7FFF_FFFF, 32'd1, 32'd0, 1'b1,
           32'h8000_0000, 1'b0, 1'b0, 1'b0);
    run_op("R1 SUB zero R8", mk(5'd2, 2'b00, 14'd0), 32'd5, 32'd5, 32'd5, 1'b1,
           32'd0, 1'b1, 1'b0, 1'b0);
    run_op("R1 ADD to zero R8", mk(5'd1, 2'b00, 14'd0), 32'hFFFF_FFFF, 32'd1, 32'd0, 1'b1,
           32'd0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_cmp();
    run_op("R2 CMP signed less", mk(5'd3, 2'b00, 14'd0), 32'hFFFF_FFFF, 32'd1, 32'd0, 1'b1,
           32'hFFFF_FFFE, 1'b1, 1'b0, 1'b0);
    run_op("R2 CMP greater", mk(5'd3, 2'b00, 14'd0), 32'd3, 32'd2, 32'd0, 1'b1,
           32'd1, 1'b0, 1'b0, 1'b0);
    run_op("R2 CMP equal", mk(5'd3, 2'b00, 14'd0), 32'd4, 32'd4, 32'd0, 1'b1,
           32'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_imm();
    run_op("R3 ANDI zext", mk(5'd0, 2'b10, 14'h3FFF), 32'hFFFF_FFFF, 32'd0, 32'd0, 1'b1,
           32'h0000_3FFF, 1'b0, 1'b0, 1'b0);
    run_op("R3 ADDI sext", mk(5'd1, 2'b10, 14'h3FFF), 32'd10, 32'd0, 32'd0, 1'b1,
           32'd9, 1'b0, 1'b0, 1'b0);
    run_op("R4 LW neg offset", mk(5'd2, 2'b10, 14'h2000), 32'h0000_0100, 32'd0, 32'd0, 1'b1,
           32'hFFFF_E100, 1'b0, 1'b0, 1'b0);
    run_op("R4 SW offset", mk(5'd3, 2'b10, 14'd4), 32'h0000_1000, 32'd0, 32'd0, 1'b1,
           32'h0000_1004, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_beq();
    run_op("R5 BEQ equal", mk(5'd4, 2'b10, 14'd0), 32'd7, 32'd99, 32'd7, 1'b1,
           32'd0, 1'b1, 1'b1, 1'b0);
    run_op("R5 BEQ differ", mk(5'd4, 2'b10, 14'd0), 32'd7, 32'd7, 32'd8, 1'b1,
           32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    run_op("R5 ADD no branch", mk(5'd1, 2'b00, 14'd0), 32'd7, 32'd1, 32'd7, 1'b1,
           32'd8, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_shift();
    run_op("R6 SLL 31", mk(5'd0, 2'b11, shp(5'd31)), 32'd1, 32'd0, 32'd0, 1'b1,
           32'h8000_0000, 1'b0, 1'b0, 1'b0);
    run_op("R6 SLR logical", mk(5'd1, 2'b11, shp(5'd31)), 32'h8000_0000, 32'd0, 32'd0, 1'b1,
           32'd1, 1'b0, 1'b0, 1'b0);
    run_op("R6 SLR fill", mk(5'd1, 2'b11, shp(5'd4)), 32'hF000_0000, 32'd0, 32'd0, 1'b1,
           32'h0F00_0000, 1'b0, 1'b0, 1'b0);
    run_op("R6 SLL out", mk(5'd0, 2'b11, shp(5'd1)), 32'h8000_0000, 32'd0, 32'd0, 1'b1,
           32'd0, 1'b1, 1'b0, 1'b0);
    run_op("R7 SLLV mask", mk(5'd2, 2'b11, shp(5'd0)), 32'd3, 32'h0000_0024, 32'd0, 1'b1,
           32'h0000_0030, 1'b0, 1'b0, 1'b0);
    run_op("R7 SLRV mask", mk(5'd3, 2'b11, shp(5'd0)), 32'hF000_0000, 32'hFFFF_FFE4, 32'd0, 1'b1,
           32'h0F00_0000, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_hold();
    run_op("R9 prep", mk(5'd2, 2'b00, 14'd0), 32'd1, 32'd1, 32'd0, 1'b1, 32'd0, 1'b1, 1'b0, 1'b0);
    run_op("R9 idle", mk(5'd1, 2'b00, 14'd0), 32'd1, 32'd1, 32'd0, 1'b0, 32'd2, 1'b1, 1'b0, 1'b0);
    run_op("R10 reg func5", mk(5'd5, 2'b00, 14'd0), 32'd1, 32'd1, 32'd0, 1'b1, 32'd0, 1'b1, 1'b0, 1'b1);
    run_op("R10 imm func7", mk(5'd7, 2'b10, 14'd3), 32'd1, 32'd1, 32'd1, 1'b1, 32'd0, 1'b1, 1'b0, 1'b1);
    run_op("R11 jump", mk(5'd1, 2'b01, 14'h1234), 32'd5, 32'd6, 32'd5, 1'b1, 32'd0, 1'b1, 1'b0, 1'b0);
    run_op("R9 clear", mk(5'd1, 2'b00, 14'd0), 32'd1, 32'd1, 32'd0, 1'b1, 32'd2, 1'b0, 1'b0, 1'b0);
    run_op("R10 shf func4", mk(5'd4, 2'b11, 14'd0), 32'd0, 32'd0, 32'd0, 1'b1, 32'd0, 1'b0, 1'b0, 1'b1);
    run_op("R11 jump zero ops", mk(5'd0, 2'b01, 14'd0), 32'd0, 32'd0, 32'd0, 1'b1, 32'd0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_reg();
    t_cmp();
    t_imm();
    t_beq();
    t_shift();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule